// File: doc/BRIEF.md
# Configuration Write Guard with Initialisation Handshake

This block sits in front of the protected configuration registers of a real-time clock: control, time, date, prescaler and alarm. Those registers may be written only after software has written two fixed key bytes, in order, to a key port. Any other key byte closes the guard again. The block also runs the handshake that software uses to freeze the calendar for loading. Software raises an initialisation request, and the block confirms it with an active flag after a set number of slow RTC clock cycles. Clearing the request releases the calendar.

A third flag tells software that the shadow copies of time and date are fresh. Software may clear it at any time. The block sets it again after a set number of slow clock cycles, provided initialisation is not requested. The slow clock reaches the block as a one-cycle tick strobe in the bus clock domain. A fourth status bit shows whether the calendar year has ever been loaded.

Top module: `rtc_wprot_guard`

## Requirements
- R1: After reset the guard is locked (`protWrEn`=0), and the initialisation request, initialisation active and synchronised flags are all 0.
- R2: A key write of 0xCA followed by a key write of 0x53 raises `protWrEn` on the clock edge that takes the second write. Idle cycles between the two key writes are allowed.
- R3: While unlocked, a key write of any value other than 0xCA (for example 0xFF) drops `protWrEn` on the edge that takes it. A key write of 0xCA while unlocked also locks, and it begins a new sequence.
- R4: If a key write other than 0xCA or 0x53 arrives between 0xCA and 0x53, the sequence returns to the locked start state, and a following 0x53 does not unlock.
- R5: A control write changes the initialisation request (status bit 7, taken from bit 7 of `ctlWrData`) only while unlocked. While locked, the request keeps its value.
- R6: Once the request is set, initialisation active (status bit 6) rises on the edge that takes the INIT_TICKS-th tick counted after the request edge. The default INIT_TICKS is 2.
- R7: A control write with bit 7 at 0, made while unlocked, clears the request and initialisation active on the same edge.
- R8: A control write with bit 5 at 0 clears the synchronised flag (status bit 5), locked or not. A write with bit 5 at 1 never sets it. While the request is low, the flag sets on the edge that takes the SYNC_TICKS-th tick after it was cleared. The default SYNC_TICKS is 2.
- R9: The edge that sets the request also clears the synchronised flag. The flag stays at 0 while the request is high.
- R10: The initialised status bit (status bit 4) is 0 exactly when the calendar year input is zero. Status bits 3..0 read 0.
- R11: `calRun` is the inverse of initialisation active. The calendar counts whenever it is not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| rtcTick | input | 1 | One-cycle strobe per slow RTC clock cycle |
| keyWrEn | input | 1 | Key port write strobe |
| keyData | input | 8 | Key byte |
| ctlWrEn | input | 1 | Status/init port write strobe |
| ctlWrData | input | 8 | Bit 7: init request; bit 5: write 0 to clear the synchronised flag |
| yearBcd | input | 8 | Current calendar year from the calendar datapath |
| protWrEn | output | 1 | Write enable for the protected registers |
| initActive | output | 1 | Initialisation mode is active |
| syncDone | output | 1 | Shadow calendar registers are synchronised |
| calRun | output | 1 | Calendar may advance |
| statusRd | output | 8 | {request, active, synchronised, initialised, 4'b0} |

## Verification
The hardest cases to reach are the ones where several events land on the same edge. One is a request clear that arrives while the init count is part-way through. Another is a synchronised-flag clear that lands in the same cycle as a tick. A third is a key byte written while the guard is already open. The bench reaches them by placing key writes, control writes and ticks in chosen cycles and by interleaving idle cycles between ticks. A behavioural model, advanced every clock, then catches any cycle in which the design and the model disagree.

// File: rtl/rtc_wprot_pkg.sv
package rtc_wprot_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_e;

  // Strobes handed from the control to the timing datapath
  typedef struct packed {
    logic unlocked;
    logic setReq;
    logic clrReq;
    logic clrSync;
  } ctlStrobe_t;

  localparam int REQ_BIT  = 7;
  localparam int ACT_BIT  = 6;
  localparam int SYNC_BIT = 5;
  localparam int INIT_BIT = 4;

endpackage

// File: rtl/rtc_wprot_ctrl.sv
module rtc_wprot_ctrl
  import rtc_wprot_pkg::*;
#(
  parameter int          KEY_W      = 8,
  parameter int          DATA_W     = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyWrEn,
  input  logic [KEY_W-1:0]  keyData,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  output ctlStrobe_t        strobe
);

  keyState_e keyState, keyNext;

  always_comb begin
    keyNext = keyState;
    if (keyWrEn) begin
      if (keyData == KEY_FIRST)
        keyNext = KEY_HALF;
      else if (keyState == KEY_HALF && keyData == KEY_SECOND)
        keyNext = KEY_OPEN;
      else
        keyNext = KEY_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) keyState <= KEY_LOCKED;
    else       keyState <= keyNext;
  end

  always_comb begin
    strobe.unlocked = (keyState == KEY_OPEN);
    strobe.setReq   = ctlWrEn && strobe.unlocked && ctlWrData[REQ_BIT];
    strobe.clrReq   = ctlWrEn && strobe.unlocked && !ctlWrData[REQ_BIT];
    strobe.clrSync  = ctlWrEn && !ctlWrData[SYNC_BIT];
  end

  AST_OPEN_AFTER_KEY2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.unlocked) |-> $past(keyWrEn && keyData == KEY_SECOND)); // R2

  AST_WRONG_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && keyData != KEY_SECOND) |=> !strobe.unlocked); // R3

  AST_HALF_BROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_HALF && keyWrEn && keyData != KEY_SECOND && keyData != KEY_FIRST)
      |=> keyState == KEY_LOCKED); // R4

endmodule

// File: rtl/rtc_wprot_timer.sv
module rtc_wprot_timer
  import rtc_wprot_pkg::*;
#(
  parameter int INIT_TICKS = 2,
  parameter int SYNC_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rtcTick,
  input  ctlStrobe_t strobe,
  output logic       initReq,
  output logic       initActive,
  output logic       syncDone
);

  localparam int ICNT_W = $clog2(INIT_TICKS + 1);
  localparam int SCNT_W = $clog2(SYNC_TICKS + 1);
  localparam logic [ICNT_W-1:0] ILAST = ICNT_W'(INIT_TICKS - 1);
  localparam logic [SCNT_W-1:0] SLAST = SCNT_W'(SYNC_TICKS - 1);

  logic [ICNT_W-1:0] initCnt;
  logic [SCNT_W-1:0] syncCnt;
  logic              enterInit;

  assign enterInit = strobe.setReq && !initReq;

  // request register
  always_ff @(posedge clk) begin
    if (!rstN)              initReq <= 1'b0;
    else if (strobe.setReq) initReq <= 1'b1;
    else if (strobe.clrReq) initReq <= 1'b0;
  end

  // request -> active handshake counted in slow ticks
  always_ff @(posedge clk) begin
    if (!rstN || !initReq || strobe.clrReq) begin
      initActive <= 1'b0;
      initCnt    <= '0;
    end else if (!initActive && rtcTick) begin
      if (initCnt == ILAST) begin
        initActive <= 1'b1;
        initCnt    <= '0;
      end else begin
        initCnt <= initCnt + 1'b1;
      end
    end
  end

  // shadow resynchronisation flag
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrSync || enterInit) begin
      syncDone <= 1'b0;
      syncCnt  <= '0;
    end else if (!syncDone && !initReq && rtcTick) begin
      if (syncCnt == SLAST) begin
        syncDone <= 1'b1;
        syncCnt  <= '0;
      end else begin
        syncCnt <= syncCnt + 1'b1;
      end
    end
  end

  AST_ACTIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initActive) |-> $past(initReq)); // R6

  AST_ACTIVE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initActive) |-> $past(rtcTick)); // R6

  AST_DROP_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(initReq) |-> !initActive); // R7

  AST_SYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncDone) |-> $past(rtcTick && !initReq)); // R8

  AST_SYNC_LOW_IN_INIT: assert property (@(posedge clk) disable iff (!rstN)
    initReq |-> !syncDone); // R9

endmodule

// File: rtl/rtc_wprot_guard.sv
module rtc_wprot_guard
  import rtc_wprot_pkg::*;
#(
  parameter int KEY_W      = 8,
  parameter int DATA_W     = 8,
  parameter int YEAR_W     = 8,
  parameter int INIT_TICKS = 2,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              keyWrEn,
  input  logic [KEY_W-1:0]  keyData,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  input  logic [YEAR_W-1:0] yearBcd,
  output logic              protWrEn,
  output logic              initActive,
  output logic              syncDone,
  output logic              calRun,
  output logic [DATA_W-1:0] statusRd
);

  ctlStrobe_t strobe;
  logic       initReq;
  logic       unusedBits;

  assign unusedBits = ^{ctlWrData[ACT_BIT], ctlWrData[INIT_BIT:0]};

  rtc_wprot_ctrl #(
    .KEY_W (KEY_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .keyWrEn  (keyWrEn),
    .keyData  (keyData),
    .ctlWrEn  (ctlWrEn),
    .ctlWrData(ctlWrData),
    .strobe   (strobe)
  );

  rtc_wprot_timer #(
    .INIT_TICKS(INIT_TICKS),
    .SYNC_TICKS(SYNC_TICKS)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .rtcTick   (rtcTick),
    .strobe    (strobe),
    .initReq   (initReq),
    .initActive(initActive),
    .syncDone  (syncDone)
  );

  assign protWrEn = strobe.unlocked;
  assign calRun   = !initActive;

  always_comb begin
    statusRd           = '0;
    statusRd[REQ_BIT]  = initReq;
    statusRd[ACT_BIT]  = initActive;
    statusRd[SYNC_BIT] = syncDone;
    statusRd[INIT_BIT] = (yearBcd != '0);
  end

  AST_LOCKED_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !protWrEn) |=> initReq == $past(initReq)); // R5

  AST_SYNC_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !ctlWrData[SYNC_BIT]) |=> !syncDone); // R8

  AST_REQ_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initReq) |-> !syncDone); // R9

endmodule

// File: tb/rtc_wprot_guard_tb.sv
module rtc_wprot_guard_tb;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rtcTick = 1'b0;
  logic       keyWrEn = 1'b0;
  logic [7:0] keyData = '0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic [7:0] yearBcd = '0;
  logic       protWrEn, initActive, syncDone, calRun;
  logic [7:0] statusRd;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int  mKey = 0;
  bit  mReq = 0, mAct = 0, mSync = 0;
  int  mIc = 0, mSc = 0;
  string curTag = "R1";

  always #(PERIOD/2) clk = ~clk;

  rtc_wprot_guard u_dut (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .keyWrEn(keyWrEn), .keyData(keyData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .yearBcd(yearBcd), .protWrEn(protWrEn),
    .initActive(initActive), .syncDone(syncDone), .calRun(calRun), .statusRd(statusRd)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelStatus();
    return {mReq, mAct, mSync, (yearBcd != 0), 4'b0};
  endfunction

  // one clock: model advances with inputs, outputs compared at the falling edge
  task automatic cyc();
    bit oldReq, unl, setR, clrR, clrS;
    @(posedge clk);
    if (!rstN) begin
      mKey = 0; mReq = 0; mAct = 0; mSync = 0; mIc = 0; mSc = 0;
    end else begin
      oldReq = mReq;
      unl  = (mKey == 2);
      setR = ctlWrEn && unl && ctlWrData[7];
      clrR = ctlWrEn && unl && !ctlWrData[7];
      clrS = ctlWrEn && !ctlWrData[5];
      if (keyWrEn) begin
        if (keyData == 8'hCA) mKey = 1;
        else if (mKey == 1 && keyData == 8'h53) mKey = 2;
        else mKey = 0;
      end
      if (!oldReq || clrR) begin mAct = 0; mIc = 0; end
      else if (!mAct && rtcTick) begin
        if (mIc == 1) begin mAct = 1; mIc = 0; end else mIc++;
      end
      if (clrS || (setR && !oldReq)) begin mSync = 0; mSc = 0; end
      else if (!mSync && !oldReq && rtcTick) begin
        if (mSc == 1) begin mSync = 1; mSc = 0; end else mSc++;
      end
      if (setR) mReq = 1; else if (clrR) mReq = 0;
    end
    @(negedge clk);
    check({curTag, " protWrEn"}, protWrEn, (mKey == 2));
    check({curTag, " status"}, statusRd, modelStatus());
    check({curTag, " calRun"}, calRun, !mAct);
    keyWrEn = 0; ctlWrEn = 0; rtcTick = 0;
  endtask

  task automatic key(input logic [7:0] k);
    keyWrEn = 1; keyData = k; cyc();
  endtask

  task automatic ctl(input logic [7:0] d);
    ctlWrEn = 1; ctlWrData = d; cyc();
  endtask

  task automatic tick();
    rtcTick = 1; cyc();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rstN = 1;
    // R1: reset state, no ticks yet
    curTag = "R1"; cyc();
    check("R1 locked", protWrEn, 0);
    check("R1 status", statusRd, 8'h00);

    // R8: synchronised flag after two ticks with idle between
    curTag = "R8"; tick(); cyc(); cyc(); tick();
    check("R8 sync set", statusRd[5], 1);

    // R5: init request while locked is ignored
    curTag = "R5"; ctl(8'hA0); cyc();
    check("R5 locked req", statusRd[7], 0);

    // R2: unlock with idle between keys
    curTag = "R2"; key(8'hCA); cyc();
    check("R2 half locked", protWrEn, 0);
    key(8'h53);
    check("R2 open", protWrEn, 1);

    // R9 / R6 / R11: enter init
    curTag = "R9"; ctl(8'hA0);
    check("R9 sync cleared on entry", statusRd[5], 0);
    check("R5 req accepted", statusRd[7], 1);
    curTag = "R6"; tick();
    check("R6 not yet active", initActive, 0);
    cyc(); tick();
    check("R6 active after two ticks", initActive, 1);
    check("R11 calendar frozen", calRun, 0);
    curTag = "R9"; tick(); tick(); tick();
    check("R9 sync held low", syncDone, 0);

    // R7: leave init
    curTag = "R7"; ctl(8'h20);
    check("R7 active dropped", initActive, 0);
    check("R11 calendar runs", calRun, 1);
    curTag = "R8"; tick(); tick();
    check("R8 resync", syncDone, 1);

    // R7 corner: clear request mid count
    curTag = "R7"; ctl(8'hA0); tick(); ctl(8'h20); tick();
    check("R7 no late active", initActive, 0);
    tick(); tick();

    // R3: wrong key relocks, then locked write ignored
    curTag = "R3"; key(8'hFF);
    check("R3 relocked", protWrEn, 0);
    curTag = "R5"; ctl(8'hA0);
    check("R5 ignored after relock", statusRd[7], 0);

    // R4: interrupted sequence
    curTag = "R4"; key(8'hCA); key(8'h11); key(8'h53);
    check("R4 stays locked", protWrEn, 0);
    // R3: 0xCA while open relocks and restarts
    curTag = "R3"; key(8'hCA); key(8'h53); key(8'hCA);
    check("R3 CA relocks", protWrEn, 0);
    key(8'h53);
    check("R3 restart opens", protWrEn, 1);
    key(8'h00);

    // R8: clear while locked, bit5 high never sets, clear on tick edge
    curTag = "R8"; tick(); tick();
    ctl(8'h00);
    check("R8 clear locked", syncDone, 0);
    ctl(8'h20);
    check("R8 write one no set", syncDone, 0);
    tick(); rtcTick = 1; ctl(8'h00); tick();
    check("R8 clear beats tick", syncDone, 0);
    tick();
    check("R8 sets again", syncDone, 1);

    // R10: initialised bit follows year
    curTag = "R10"; yearBcd = 8'h24; cyc();
    check("R10 year set", statusRd[4], 1);
    check("R10 low bits", statusRd[3:0], 0);
    yearBcd = 8'h00; cyc();
    check("R10 year zero", statusRd[4], 0);

    // R1: reset again from an active state
    curTag = "R1"; key(8'hCA); key(8'h53); ctl(8'h80); tick(); tick();
    rstN = 0; cyc(); rstN = 1;
    check("R1 reset clears", {protWrEn, statusRd}, 0);
    cyc();
    done = 1;
    summary();
  end

endmodule